// File: doc/BRIEF.md
# Dual-Index Swapping Register Bank

This block holds a byte permutation table of 256 entries, each eight bits wide, in plain registers. Two index inputs name two entries at once. A swap takes one clock: on the falling edge the bank latches both indices and the two entries they select. On the next rising edge it writes each latched value into the other's location. The exchanged table can therefore be read again before the following falling edge, so a driver can issue one swap per clock.

A third combinational port returns the entry at a lookup index, independently of the swap indices, for keystream selection. Two combinational read outputs present the entries currently addressed by the two swap indices. The table is set to the identity permutation by a synchronous reset or by an explicit initialise strobe. Index arithmetic, key handling and sequencing belong to the units that drive the bank.

Top module: `permSwapBank`

## Requirements
- R1: With `rst` high at a rising edge, every entry k afterwards holds the value k.
- R2: With `initTable` high at a rising edge, every entry k afterwards holds k. This holds even if a swap was armed for that same edge; the initialise wins.
- R3: If `swapEn` is high at a falling edge with indices a and b (a not equal to b), the next rising edge exchanges the entries at a and b. No other entry changes.
- R4: A swap whose two indices are equal leaves the whole table unchanged.
- R5: If `swapEn` is low at a falling edge, the next rising edge changes no entry.
- R6: `rdDataI` and `rdDataJ` show, combinationally, the current entries at `idxI` and `idxJ`, including values written at the latest rising edge.
- R7: `lookupData` shows, combinationally, the current entry at `lookupIdx`. It answers for any index, including while a swap is pending on other indices.
- R8: Swaps armed at consecutive falling edges are each applied at their own rising edge, so one swap per clock accumulates.
- R9: Index and enable values are taken at the falling edge. Changing `idxI`, `idxJ` or `swapEn` between that falling edge and the next rising edge does not alter the swap performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; falling edge latches, rising edge writes |
| rst | input | 1 | Synchronous reset to identity |
| initTable | input | 1 | Synchronous load of identity permutation |
| swapEn | input | 1 | Arms a swap at the falling edge |
| idxI | input | 8 | First swap index |
| idxJ | input | 8 | Second swap index |
| rdDataI | output | 8 | Current entry at idxI |
| rdDataJ | output | 8 | Current entry at idxJ |
| lookupIdx | input | 8 | Independent lookup index |
| lookupData | output | 8 | Current entry at lookupIdx |

## Verification
Two functions can coincide in the same cycle. An initialise strobe can arrive at the rising edge that would commit an armed swap. Separately, the lookup port can be read while a swap on the same entries is pending. The bench arms a swap on a scrambled table and raises `initTable` before the commit edge; a full sweep through the lookup port must then show pure identity. In another cycle it points the lookup index at a pending swap location between the falling and rising edges. It expects the pre-swap value there and the exchanged value just after the rising edge.

// File: rtl/permBankPkg.sv
package permBankPkg;

  // Strobes sent from the control to the datapath for each rising edge.
  typedef struct packed {
    logic loadId;   // write identity into every entry
    logic commit;   // write the latched exchange
  } bankStrobe_t;

endpackage

// File: rtl/permBankCtrl.sv
module permBankCtrl
  import permBankPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        initTable,
  input  logic        swapEn,
  output bankStrobe_t strb
);

  logic armed;

  // Swap request is taken at the falling edge, half a cycle before commit.
  always_ff @(negedge clk) begin
    armed <= swapEn & ~rst;
  end

  always_comb begin
    strb.loadId = rst | initTable;
    strb.commit = armed & ~(rst | initTable);
  end

endmodule

// File: rtl/permBankData.sv
module permBankData
  import permBankPkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bankStrobe_t       strb,
  input  logic [IDX_W-1:0]  idxI,
  input  logic [IDX_W-1:0]  idxJ,
  input  logic [IDX_W-1:0]  lookupIdx,
  output logic [DATA_W-1:0] rdDataI,
  output logic [DATA_W-1:0] rdDataJ,
  output logic [DATA_W-1:0] lookupData
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] entries [DEPTH];
  logic [IDX_W-1:0]  holdIdxI, holdIdxJ;
  logic [DATA_W-1:0] holdValI, holdValJ;

  // Falling edge: latch both indices and the entries they select.
  always_ff @(negedge clk) begin
    holdIdxI <= idxI;
    holdIdxJ <= idxJ;
    holdValI <= entries[idxI];
    holdValJ <= entries[idxJ];
  end

  // Rising edge: identity load or crossed write-back. Location I takes the
  // value from J first, so equal indices write back the unchanged value.
  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (strb.loadId)
        entries[k] <= DATA_W'(k);
      else if (strb.commit && holdIdxI == IDX_W'(k))
        entries[k] <= holdValJ;
      else if (strb.commit && holdIdxJ == IDX_W'(k))
        entries[k] <= holdValI;
    end
  end

  always_comb begin
    rdDataI    = entries[idxI];
    rdDataJ    = entries[idxJ];
    lookupData = entries[lookupIdx];
  end

  // R1: reset leaves the identity at both ends of the table
  a_r1_reset_identity: assert property (@(posedge clk)
    rst |=> (entries[0] == DATA_W'(0) && entries[DEPTH-1] == DATA_W'(DEPTH-1)));

  // R3: the value latched from I lands at J
  a_r3_swap_lands: assert property (@(posedge clk) disable iff (rst)
    (strb.commit && holdIdxI != holdIdxJ) |=> entries[$past(holdIdxJ)] == $past(holdValI));

  // R4: equal indices keep the entry
  a_r4_same_index: assert property (@(posedge clk) disable iff (rst)
    (strb.commit && holdIdxI == holdIdxJ) |=> entries[$past(holdIdxI)] == $past(holdValI));

  // R5: no strobe, no change at the latched location
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!strb.commit && !strb.loadId) |=> entries[$past(holdIdxI)] == $past(holdValI));

  // R2: initialise leaves the identity behind
  a_r2_init_identity: assert property (@(posedge clk) disable iff (rst)
    strb.loadId |=> (entries[1] == DATA_W'(1) && entries[DEPTH-2] == DATA_W'(DEPTH-2)));

endmodule

// File: rtl/permSwapBank.sv
module permSwapBank
  import permBankPkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              initTable,
  input  logic              swapEn,
  input  logic [IDX_W-1:0]  idxI,
  input  logic [IDX_W-1:0]  idxJ,
  output logic [DATA_W-1:0] rdDataI,
  output logic [DATA_W-1:0] rdDataJ,
  input  logic [IDX_W-1:0]  lookupIdx,
  output logic [DATA_W-1:0] lookupData
);

  bankStrobe_t strb;

  permBankCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .initTable (initTable),
    .swapEn    (swapEn),
    .strb      (strb)
  );

  permBankData #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .idxI       (idxI),
    .idxJ       (idxJ),
    .lookupIdx  (lookupIdx),
    .rdDataI    (rdDataI),
    .rdDataJ    (rdDataJ),
    .lookupData (lookupData)
  );

endmodule

// File: tb/test_permSwapBank.sv
module test_permSwapBank;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       initTable = 1'b0;
  logic       swapEn = 1'b0;
  logic [7:0] idxI = '0, idxJ = '0, lookupIdx = '0;
  logic [7:0] rdDataI, rdDataJ, lookupData;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [256];

  // {enable, i, j}
  localparam logic [16:0] VEC [0:9] = '{
    {1'b1, 8'd0,   8'd5},   {1'b1, 8'd5,   8'd0},
    {1'b1, 8'd3,   8'd3},   {1'b0, 8'd7,   8'd9},
    {1'b1, 8'd255, 8'd0},   {1'b1, 8'd128, 8'd127},
    {1'b1, 8'd1,   8'd2},   {1'b0, 8'd255, 8'd255},
    {1'b1, 8'd200, 8'd17},  {1'b1, 8'd17,  8'd17}
  };

  always #10 clk = ~clk;

  permSwapBank i_permSwapBank (
    .clk(clk), .rst(rst), .initTable(initTable), .swapEn(swapEn),
    .idxI(idxI), .idxJ(idxJ), .rdDataI(rdDataI), .rdDataJ(rdDataJ),
    .lookupIdx(lookupIdx), .lookupData(lookupData)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelIdentity();
    for (int k = 0; k < 256; k++) model[k] = 8'(k);
  endtask

  task automatic modelSwap(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] tmp;
    tmp = model[a]; model[a] = model[b]; model[b] = tmp;
  endtask

  // Full sweep through the lookup port, counted as one check.
  task automatic sweep(input string tag);
    int bad = -1;
    logic [7:0] got = '0;
    for (int k = 0; k < 256; k++) begin
      lookupIdx = 8'(k);
      #0.1;
      if (lookupData !== model[k] && bad < 0) begin bad = k; got = lookupData; end
    end
    tests++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s entry %0d actual=%0d expected=%0d", tag, bad, got, model[bad]);
    end
  endtask

  task automatic step(input logic en, input logic [7:0] a, input logic [7:0] b, input string tag);
    @(posedge clk); #2;
    swapEn = en; idxI = a; idxJ = b;
    @(posedge clk); #2;
    swapEn = 1'b0;
    if (en) modelSwap(a, b);
    check8({tag, " R6 rdDataI"}, rdDataI, model[a]);
    check8({tag, " R6 rdDataJ"}, rdDataJ, model[b]);
    sweep(tag);
  endtask

  initial begin
    #(200000 * 20);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    modelIdentity();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    sweep("R1 reset identity");

    // Vector table walk: R3 swaps, R4 equal index, R5 disabled
    for (int v = 0; v < 10; v++)
      step(VEC[v][16], VEC[v][15:8], VEC[v][7:0],
           VEC[v][16] ? (VEC[v][15:8] == VEC[v][7:0] ? "R4 equal" : "R3 swap") : "R5 idle");

    // R8: back-to-back swaps, one per clock
    @(posedge clk); #2;
    swapEn = 1'b1; idxI = 8'd10; idxJ = 8'd20;
    @(posedge clk); #2; modelSwap(8'd10, 8'd20); idxI = 8'd20; idxJ = 8'd30;
    @(posedge clk); #2; modelSwap(8'd20, 8'd30); idxI = 8'd30; idxJ = 8'd10;
    @(posedge clk); #2; modelSwap(8'd30, 8'd10); swapEn = 1'b0;
    check8("R8 chain rdDataI", rdDataI, model[30]);
    sweep("R8 chain");

    // R7 and R9: lookup during a pending swap; indices changed after falling edge
    @(posedge clk); #2;
    swapEn = 1'b1; idxI = 8'd40; idxJ = 8'd50; lookupIdx = 8'd40;
    @(negedge clk); #2;
    check8("R7 lookup before commit", lookupData, model[40]);
    idxI = 8'd60; swapEn = 1'b0;
    @(posedge clk); #2;
    modelSwap(8'd40, 8'd50);
    lookupIdx = 8'd40; #0.1;
    check8("R7 lookup after commit", lookupData, model[40]);
    sweep("R9 falling-edge capture");

    // R2: initialise beats an armed swap
    @(posedge clk); #2;
    swapEn = 1'b1; idxI = 8'd1; idxJ = 8'd2;
    @(negedge clk); #2; initTable = 1'b1;
    @(posedge clk); #2; initTable = 1'b0; swapEn = 1'b0;
    modelIdentity();
    sweep("R2 init over swap");

    // R1: reset mid-run with swap armed
    step(1'b1, 8'd9, 8'd99, "R3 pre-reset");
    @(posedge clk); #2; swapEn = 1'b1; idxI = 8'd4; idxJ = 8'd8; rst = 1'b1;
    @(posedge clk); #2; rst = 1'b0; swapEn = 1'b0;
    modelIdentity();
    sweep("R1 reset mid-run");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule